// File: doc/BRIEF.md
# Interrupt Entry and Core Reset Sequencer

This block sits next to a simple in-order core and performs the bookkeeping of taking an interrupt. Requests arrive on three valid/ready channels, one per class: noncritical, critical and machine check. Each request carries an interrupt type and a cause syndrome. In every cycle the block accepts at most one request. For that request it stores a return address in the save register of its class and, when the type has more than one possible cause, stores the syndrome in that class's syndrome register. One cycle later it issues a one-cycle fetch redirect to the type's vector.

The vector is formed from a programmable base register. Its upper bits are followed by the 3-bit type number and four zero bits, so every entry sits 16 bytes apart. A per-type parameter mask decides whether the saved address is the faulting instruction (`cur_pc_i`) or the following one (`next_pc_i`).

The block also drives the core reset. Reset follows the hard reset pin directly. It can also come from a software write to the debug trigger register, but that path only works while the core's debug-enable state bit is 1. The block's own registers are cleared by `rst_n`, not by the core reset it produces.

Top module: `irq_entry_seq`

## Requirements
- R1: While `hreset_i` is 1, `core_rst_o` is 1 in the same cycle.
- R2: A write to register address 7 with bit 2 of the data set, while `dbg_en_i` is 1, makes `core_rst_o` 1 for exactly the cycle after the write edge.
- R3: The same write with `dbg_en_i` at 0, or a write to address 7 with bit 2 clear, produces no core reset.
- R4: At most one `req_ready_o` bit is 1, and only for a valid channel. Channel 2 (machine check) wins over channel 1 (critical), which wins over channel 0 (noncritical). A channel that is not ready must hold its payload until it is.
- R5: An accepted request from channel c stores its return address in the save register at address 1+c.
- R6: The saved address is `next_pc_i` when bit t of the next-address mask (default 8'hC6) is 1 for type t, and `cur_pc_i` otherwise.
- R7: The syndrome register at address 4+c takes the request's syndrome only when bit t of the syndrome mask (default 8'h73) is 1. Otherwise it keeps its value.
- R8: One cycle after acceptance, `redir_valid_o` pulses for one cycle with `redir_addr_o` = {base[31:7], type[2:0], 4'b0000}. No pulse follows a cycle with no acceptance.
- R9: Registers are base (0), save registers (1 to 3) and syndrome registers (4 to 6). All clear to zero on reset and can be written and read back. Bits 6:0 of the base always read zero, and address 7 reads zero.
- R10: When an acceptance and a register write target the same register in one cycle, the acceptance's value is kept. A write to a syndrome register that the acceptance does not load still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| hreset_i | input | 1 | Hard reset pin |
| dbg_en_i | input | 1 | Core debug-enable state bit |
| req_valid_i | input | 3 | Request valid per class (0 nc, 1 crit, 2 mchk) |
| req_ready_o | output | 3 | Request accepted this cycle, per class |
| req_type_i | input | 9 | 3-bit type per class, class c at bits 3c+2:3c |
| req_syn_i | input | 96 | 32-bit syndrome per class, class c at bits 32c+31:32c |
| cur_pc_i | input | 32 | Address of the faulting instruction |
| next_pc_i | input | 32 | Address of the following instruction |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| redir_valid_o | output | 1 | Fetch redirect pulse |
| redir_addr_o | output | 32 | Fetch redirect target |
| core_rst_o | output | 1 | Core reset request |

## Verification
The bench drives requests from all three classes at once in every combination. A wrong priority order would show up as the wrong ready bit and as a save register filled in the wrong class. It uses types on both sides of each mask. A design that ignored the masks would save `cur_pc_i` where `next_pc_i` is due, or would overwrite a syndrome that must stay unchanged. It also collides an acceptance with a register write to the same register, and it tries the software reset with debug disabled and with the wrong data bit. In that case a design that did not gate the path would pulse `core_rst_o`.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    CLS_NC = 2'd0,
    CLS_CR = 2'd1,
    CLS_MC = 2'd2
  } irq_cls_e;

  localparam int NCLS        = 3;
  localparam int VEC_SLOT_W  = 4;
  localparam logic [2:0] RA_VBASE  = 3'd0;
  localparam logic [2:0] RA_SAVE0  = 3'd1;
  localparam logic [2:0] RA_SYN0   = 3'd4;
  localparam logic [2:0] RA_DBGTRG = 3'd7;
endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N = 3
) (
  input  logic [N-1:0]         valid,
  output logic [N-1:0]         grant,
  output logic [$clog2(N)-1:0] win,
  output logic                 any
);
  // higher index has higher priority: later iterations overwrite
  always_comb begin
    grant = '0;
    win   = '0;
    for (int i = 0; i < N; i++) begin
      if (valid[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        win      = i[$clog2(N)-1:0];
      end
    end
    any = |valid;
  end
endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs
  import irq_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int TYPE_W = 3,
  parameter logic [(1<<TYPE_W)-1:0] SAVE_NEXT_MASK = 8'hC6,
  parameter logic [(1<<TYPE_W)-1:0] SYN_EN_MASK    = 8'h73
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [1:0]        take_cls,
  input  logic [TYPE_W-1:0] take_type,
  input  logic [XLEN-1:0]   take_syn,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   next_pc,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [XLEN-1:0]   reg_wdata,
  output logic [XLEN-1:0]   reg_rdata,
  output logic [XLEN-OFF_W-1:0] vbase_hi
);
  localparam int OFF_W = TYPE_W + VEC_SLOT_W;

  logic [NCLS-1:0][XLEN-1:0] save_q;
  logic [NCLS-1:0][XLEN-1:0] syn_q;
  logic [XLEN-OFF_W-1:0]     vbase_q;
  logic [XLEN-1:0]           ret_addr;
  logic                      syn_load;

  assign ret_addr = SAVE_NEXT_MASK[take_type] ? next_pc : cur_pc;
  assign syn_load = take && SYN_EN_MASK[take_type];
  assign vbase_hi = vbase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_q  <= '0;
      syn_q   <= '0;
      vbase_q <= '0;
    end else begin
      if (reg_we && reg_addr == RA_VBASE)
        vbase_q <= reg_wdata[XLEN-1:OFF_W];
      for (int c = 0; c < NCLS; c++) begin
        if (take && take_cls == 2'(c))
          save_q[c] <= ret_addr;
        else if (reg_we && reg_addr == RA_SAVE0 + 3'(c))
          save_q[c] <= reg_wdata;
        if (syn_load && take_cls == 2'(c))
          syn_q[c] <= take_syn;
        else if (reg_we && reg_addr == RA_SYN0 + 3'(c))
          syn_q[c] <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_VBASE:   reg_rdata = {vbase_q, {OFF_W{1'b0}}};
      3'd1:       reg_rdata = save_q[0];
      3'd2:       reg_rdata = save_q[1];
      3'd3:       reg_rdata = save_q[2];
      3'd4:       reg_rdata = syn_q[0];
      3'd5:       reg_rdata = syn_q[1];
      3'd6:       reg_rdata = syn_q[2];
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
  import irq_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int TYPE_W = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              take,
  input  logic [TYPE_W-1:0]                 take_type,
  input  logic [XLEN-TYPE_W-VEC_SLOT_W-1:0] vbase_hi,
  output logic                              redir_valid,
  output logic [XLEN-1:0]                   redir_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_addr  <= '0;
    end else begin
      redir_valid <= take;
      if (take)
        redir_addr <= {vbase_hi, take_type, {VEC_SLOT_W{1'b0}}};
    end
  end
endmodule

// File: rtl/irq_rst_gen.sv
module irq_rst_gen
  import irq_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int RST_BIT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hreset,
  input  logic            dbg_en,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [XLEN-1:0] reg_wdata,
  output logic            core_rst
);
  logic sw_q;
  logic trig;

  assign trig = reg_we && reg_addr == RA_DBGTRG && reg_wdata[RST_BIT] && dbg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= 1'b0;
    else        sw_q <= trig;
  end

  assign core_rst = hreset | sw_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int TYPE_W  = 3,
  parameter int RST_BIT = 2,
  parameter logic [(1<<TYPE_W)-1:0] SAVE_NEXT_MASK = 8'hC6,
  parameter logic [(1<<TYPE_W)-1:0] SYN_EN_MASK    = 8'h73
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hreset_i,
  input  logic                   dbg_en_i,
  input  logic [2:0]             req_valid_i,
  output logic [2:0]             req_ready_o,
  input  logic [3*TYPE_W-1:0]    req_type_i,
  input  logic [3*XLEN-1:0]      req_syn_i,
  input  logic [XLEN-1:0]        cur_pc_i,
  input  logic [XLEN-1:0]        next_pc_i,
  input  logic                   reg_we_i,
  input  logic [2:0]             reg_addr_i,
  input  logic [XLEN-1:0]        reg_wdata_i,
  output logic [XLEN-1:0]        reg_rdata_o,
  output logic                   redir_valid_o,
  output logic [XLEN-1:0]        redir_addr_o,
  output logic                   core_rst_o
);
  localparam int OFF_W = TYPE_W + VEC_SLOT_W;

  logic [1:0]            win;
  logic                  take;
  logic [TYPE_W-1:0]     take_type;
  logic [XLEN-1:0]       take_syn;
  logic [XLEN-OFF_W-1:0] vbase_hi;

  irq_prio_arb #(.N(NCLS)) u_arb (
    .valid (req_valid_i),
    .grant (req_ready_o),
    .win   (win),
    .any   (take)
  );

  assign take_type = req_type_i[win*TYPE_W +: TYPE_W];
  assign take_syn  = req_syn_i[win*XLEN +: XLEN];

  irq_ctx_regs #(
    .XLEN(XLEN), .TYPE_W(TYPE_W),
    .SAVE_NEXT_MASK(SAVE_NEXT_MASK), .SYN_EN_MASK(SYN_EN_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .take(take), .take_cls(win), .take_type(take_type), .take_syn(take_syn),
    .cur_pc(cur_pc_i), .next_pc(next_pc_i),
    .reg_we(reg_we_i), .reg_addr(reg_addr_i), .reg_wdata(reg_wdata_i),
    .reg_rdata(reg_rdata_o), .vbase_hi(vbase_hi)
  );

  irq_vec_gen #(.XLEN(XLEN), .TYPE_W(TYPE_W)) u_vec (
    .clk(clk), .rst_n(rst_n),
    .take(take), .take_type(take_type), .vbase_hi(vbase_hi),
    .redir_valid(redir_valid_o), .redir_addr(redir_addr_o)
  );

  irq_rst_gen #(.XLEN(XLEN), .RST_BIT(RST_BIT)) u_rst (
    .clk(clk), .rst_n(rst_n),
    .hreset(hreset_i), .dbg_en(dbg_en_i),
    .reg_we(reg_we_i), .reg_addr(reg_addr_i), .reg_wdata(reg_wdata_i),
    .core_rst(core_rst_o)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int XLEN    = 32,
  parameter int TYPE_W  = 3,
  parameter int RST_BIT = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hreset_i,
  input logic                dbg_en_i,
  input logic [2:0]          req_valid_i,
  input logic [2:0]          req_ready_o,
  input logic                reg_we_i,
  input logic [2:0]          reg_addr_i,
  input logic [XLEN-1:0]     reg_wdata_i,
  input logic                redir_valid_o,
  input logic [XLEN-1:0]     redir_addr_o,
  input logic                core_rst_o
);
  AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready_o)); // R4
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready_o & ~req_valid_i) == 3'b000); // R4
  AST_MCHK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i[2] |-> req_ready_o[2]); // R4
  AST_CRIT_OVER_NC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i[1] && !req_valid_i[2]) |-> req_ready_o[1]); // R4
  AST_REDIR_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready_o) |=> redir_valid_o); // R8
  AST_NO_REDIR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_ready_o) |=> !redir_valid_o); // R8
  AST_REDIR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid_o |-> redir_addr_o[3:0] == 4'b0000); // R8
  AST_HARD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    hreset_i |-> core_rst_o); // R1
  AST_SW_RESET_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_o && !hreset_i) |->
      $past(reg_we_i && reg_addr_i == 3'd7 && reg_wdata_i[RST_BIT] && dbg_en_i)); // R3
endmodule

bind irq_entry_seq irq_entry_chk #(.XLEN(XLEN), .TYPE_W(TYPE_W), .RST_BIT(RST_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .hreset_i(hreset_i), .dbg_en_i(dbg_en_i),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .redir_valid_o(redir_valid_o), .redir_addr_o(redir_addr_o), .core_rst_o(core_rst_o)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  localparam logic [7:0] NEXT_MASK = 8'hC6;
  localparam logic [7:0] SYN_MASK  = 8'h73;
  localparam logic [31:0] VBASE    = 32'h8000_1234;
  localparam int NVEC = 9;
  // {expected class[1:0], valid[2:0], type mc, type cr, type nc}
  localparam logic [13:0] VEC [NVEC] = '{
    {2'd0, 3'b001, 3'd0, 3'd0, 3'd0},
    {2'd0, 3'b001, 3'd0, 3'd0, 3'd2},
    {2'd1, 3'b010, 3'd0, 3'd1, 3'd0},
    {2'd2, 3'b100, 3'd7, 3'd0, 3'd0},
    {2'd1, 3'b011, 3'd0, 3'd4, 3'd3},
    {2'd2, 3'b111, 3'd0, 3'd6, 3'd5},
    {2'd2, 3'b110, 3'd6, 3'd5, 3'd0},
    {2'd2, 3'b101, 3'd1, 3'd0, 3'd6},
    {2'd1, 3'b011, 3'd0, 3'd7, 3'd1}
  };

  logic clk = 0, rst_n = 0, hreset = 0, dbg_en = 0;
  logic [2:0] req_valid = '0, req_ready;
  logic [8:0] req_type = '0;
  logic [95:0] req_syn = '0;
  logic [31:0] cur_pc = '0, next_pc = '0;
  logic reg_we = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, redir_addr;
  logic redir_valid, core_rst;
  int compared = 0, mismatched = 0;
  logic [31:0] exp_save [3];
  logic [31:0] exp_syn [3];

  always #2 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .hreset_i(hreset), .dbg_en_i(dbg_en),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_type_i(req_type),
    .req_syn_i(req_syn), .cur_pc_i(cur_pc), .next_pc_i(next_pc),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .redir_valid_o(redir_valid), .redir_addr_o(redir_addr),
    .core_rst_o(core_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic check_regs(input string req);
    logic [31:0] v;
    for (int c = 0; c < 3; c++) begin
      rd(3'(1 + c), v); chk({req, " save"}, v, exp_save[c]);
      rd(3'(4 + c), v); chk({req, " syn"}, v, exp_syn[c]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < 3; c++) begin exp_save[c] = '0; exp_syn[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    check_regs("R9 reset");
    rd(3'd0, v); chk("R9 reset base", v, 32'h0);
    chk("R1 no reset idle", {31'b0, core_rst}, 32'h0);
    chk("R8 no redirect idle", {31'b0, redir_valid}, 32'h0);
    // R9: base low bits read zero
    wr(3'd0, VBASE);
    rd(3'd0, v); chk("R9 base", v, VBASE & ~32'h7F);
    rd(3'd7, v); chk("R9 addr7 reads zero", v, 32'h0);

    // table walk: R4 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] ec;
      logic [2:0] et;
      ec = VEC[i][13:12];
      @(negedge clk);
      req_valid = VEC[i][11:9];
      req_type  = VEC[i][8:0];
      for (int c = 0; c < 3; c++) req_syn[c*32 +: 32] = 32'h5A00_0000 + 32'(i * 16 + c);
      cur_pc  = 32'h0001_0000 + 32'(i * 8);
      next_pc = cur_pc + 4;
      et = req_type[ec*3 +: 3];
      #1 chk("R4 ready", {29'b0, req_ready}, 32'(3'b001 << ec));
      exp_save[ec] = NEXT_MASK[et] ? next_pc : cur_pc;                // R6 R5
      if (SYN_MASK[et]) exp_syn[ec] = req_syn[ec*32 +: 32];           // R7
      @(negedge clk);
      req_valid = '0;
      chk("R8 redirect valid", {31'b0, redir_valid}, 32'h1);
      chk("R8 redirect addr", redir_addr, (VBASE & ~32'h7F) | (32'(et) << 4));
      @(negedge clk);
      chk("R8 single pulse", {31'b0, redir_valid}, 32'h0);
      check_regs("R5 R6 R7");
    end

    // R9: direct write/readback
    wr(3'd2, 32'hCAFE_0002); exp_save[1] = 32'hCAFE_0002;
    wr(3'd6, 32'h0BAD_0006); exp_syn[2]  = 32'h0BAD_0006;
    check_regs("R9 rw");

    // R10: capture beats write to same save register
    @(negedge clk);
    req_valid = 3'b001; req_type = 9'd0; req_syn = {3{32'h1111_2222}};
    cur_pc = 32'h0002_0000; next_pc = 32'h0002_0004;
    reg_we = 1; reg_addr = 3'd1; reg_wdata = 32'hDEAD_0001;
    @(negedge clk); reg_we = 0; req_valid = '0;
    exp_save[0] = 32'h0002_0000; exp_syn[0] = 32'h1111_2222;
    rd(3'd1, v); chk("R10 capture wins save", v, exp_save[0]);
    rd(3'd4, v); chk("R10 capture wins syn", v, exp_syn[0]);
    // R10: type 2 does not load syndrome, so the write lands
    @(negedge clk);
    req_valid = 3'b001; req_type = 9'd2;
    reg_we = 1; reg_addr = 3'd4; reg_wdata = 32'h0000_BEEF;
    @(negedge clk); reg_we = 0; req_valid = '0;
    exp_save[0] = 32'h0002_0004; exp_syn[0] = 32'h0000_BEEF;
    check_regs("R10 write lands");

    // R1: hard reset pin
    @(negedge clk); hreset = 1; #1 chk("R1 hard reset", {31'b0, core_rst}, 32'h1);
    @(negedge clk); hreset = 0; #1 chk("R1 hard reset release", {31'b0, core_rst}, 32'h0);

    // R3: software reset without debug enable, and with wrong bit
    dbg_en = 0;
    wr(3'd7, 32'h4);
    chk("R3 gated by debug enable", {31'b0, core_rst}, 32'h0);
    dbg_en = 1;
    wr(3'd7, 32'hFFFF_FFFB);
    chk("R3 wrong bit", {31'b0, core_rst}, 32'h0);

    // R2: software reset with debug enable
    @(negedge clk); reg_we = 1; reg_addr = 3'd7; reg_wdata = 32'h4;
    @(posedge clk); #1 chk("R2 sw reset pulse", {31'b0, core_rst}, 32'h1);
    @(negedge clk); reg_we = 0;
    @(posedge clk); #1 chk("R2 sw reset one cycle", {31'b0, core_rst}, 32'h0);
    dbg_en = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule